// File: doc/BRIEF.md
# Address Range Access Protection Unit

The block watches every access on a memory bus (address plus a read/write flag) and decides whether the configured access rights allow it. Software sets up six naturally aligned address windows. Each window has a base address and a size code that gives the window size as a power of two. A rights register holds, for each window, a separate read grant and write grant. It also holds a fallback read grant and a fallback write grant for addresses that fall in no window, a master enable and a test bit.

When an access breaks the rules, the block raises a one-cycle interrupt pulse. Read violations and write violations have separate pulses. The block also records the address of the offending access in a capture register. The first captured address stays there until software reads or writes that register, so a burst of faults does not overwrite the one that started it. The block only flags accesses. The bus cycle itself runs to completion.

Software reaches the eight registers through a small select/strobe port. Reads are combinational on the select lines, and the read strobe exists only for its side effect on the capture register.

Top module: `apu_top`

## Requirements
- R1: After reset every register reads zero and `irq_vec` is zero.
- R2: A write to select 0..5 loads window n. Data bits 31:9 hold the base and bits 4:0 hold the size code. Reading the window back returns those bits, with bits 8:5 zero. All-ones therefore reads back as 0xFFFFFE1F.
- R3: Select 6 is the rights register. Bits 5:0 are the per-window write grants and bits 15:10 the per-window read grants. Bit 9 is the fallback write grant and bit 19 the fallback read grant. Bit 30 is the test bit and bit 31 the master enable. All other bits read zero, so all-ones reads back as 0xC008FE3F.
- R4: An address hits window n only when its size code c lies in 9..21 and address bits 31:c equal base bits 31:c. The low end of the window (base + 0) and the last byte (base + 2^c − 1) both hit, and base + 2^c does not. A code outside 9..21 never hits.
- R5: When an access hits one or more windows, it is allowed if at least one hit window grants its direction.
- R6: When an access hits no window, the fallback grant for its direction (bit 9 for writes, bit 19 for reads) decides.
- R7: With the master enable clear, no access raises an interrupt.
- R8: With both the master enable and the test bit set, every access is flagged as a violation, whatever the grants are.
- R9: A violating access raises exactly one interrupt bit for exactly one cycle, in the cycle after the access. Reads raise bit 23 and writes raise bit 22. All other bits of `irq_vec` stay zero.
- R10: Select 7 reads the capture register. On a violation while the register is unlocked, it loads the access address and locks. While it is locked, later violations leave it unchanged. A read strobe or a write to select 7 unlocks it, and a write also loads the written value.
- R11: A cycle with `acc_valid` low raises no interrupt and captures nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (unlocks the capture register when select is 7) |
| cfg_sel | input | 3 | Register select: 0..5 windows, 6 rights, 7 capture |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_sel` (combinational) |
| acc_valid | input | 1 | A bus access is present this cycle |
| acc_write | input | 1 | 1 for a write access, 0 for a read |
| acc_addr | input | 32 | Byte address of the access |
| irq_vec | output | 32 | Interrupt word: bit 23 read violation, bit 22 write violation |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before any checks begin. They also assume that `acc_write` is a meaningful direction whenever `acc_valid` is high. The capture-hold property assumes that software touches select 7 only through the strobes. The bench drives every input at the falling edge and holds each one steady across the following rising edge. It never asserts a register strobe together with an access, so register and bus events never meet in one cycle. Randomized addresses are biased toward the configured windows, and randomized size codes include a few invalid values, so that hit, miss and disabled windows all appear.

// File: rtl/apu_pkg.sv
package apu_pkg;

    localparam int unsigned REG_W    = 32;
    localparam int unsigned NRANGE   = 6;
    localparam int unsigned CODE_W   = 5;
    localparam int unsigned CODE_MIN = 9;
    localparam int unsigned CODE_MAX = 21;
    localparam int unsigned SEL_W    = 3;

    // rights register bit positions
    localparam int unsigned PRV_WEN_LSB = 0;
    localparam int unsigned PRV_GWR     = 9;
    localparam int unsigned PRV_REN_LSB = 10;
    localparam int unsigned PRV_GRD     = 19;
    localparam int unsigned PRV_TEST    = 30;
    localparam int unsigned PRV_ON      = 31;

    // interrupt word bit positions
    localparam int unsigned IRQ_RD = 23;
    localparam int unsigned IRQ_WR = 22;

    localparam logic [SEL_W-1:0] SEL_PRIV  = SEL_W'(6);
    localparam logic [SEL_W-1:0] SEL_VADDR = SEL_W'(7);

    typedef struct packed {
        logic [REG_W-1:CODE_MIN] base;
        logic [CODE_W-1:0]       code;
    } range_cfg_t;

    typedef struct packed {
        logic              on;
        logic              test;
        logic              glob_rd;
        logic              glob_wr;
        logic [NRANGE-1:0] rd_en;
        logic [NRANGE-1:0] wr_en;
    } priv_t;

    function automatic priv_t priv_unpack(logic [REG_W-1:0] w);
        priv_t p;
        p.on      = w[PRV_ON];
        p.test    = w[PRV_TEST];
        p.glob_rd = w[PRV_GRD];
        p.glob_wr = w[PRV_GWR];
        p.rd_en   = w[PRV_REN_LSB +: NRANGE];
        p.wr_en   = w[PRV_WEN_LSB +: NRANGE];
        return p;
    endfunction

    function automatic logic [REG_W-1:0] priv_pack(priv_t p);
        logic [REG_W-1:0] w;
        w = '0;
        w[PRV_ON]                  = p.on;
        w[PRV_TEST]                = p.test;
        w[PRV_GRD]                 = p.glob_rd;
        w[PRV_GWR]                 = p.glob_wr;
        w[PRV_REN_LSB +: NRANGE]   = p.rd_en;
        w[PRV_WEN_LSB +: NRANGE]   = p.wr_en;
        return w;
    endfunction

endpackage

// File: rtl/apu_range_match.sv
module apu_range_match #(
    parameter int unsigned AW       = 32,
    parameter int unsigned CODE_W   = 5,
    parameter int unsigned CODE_MIN = 9,
    parameter int unsigned CODE_MAX = 21
) (
    input  logic [AW-1:CODE_MIN] addr_hi,
    input  logic [AW-1:CODE_MIN] base,
    input  logic [CODE_W-1:0]    code,
    output logic                 hit
);
    logic [AW-1:CODE_MIN] keep;
    logic [AW-1:CODE_MIN] diff;
    logic                 code_ok;

    // bit j takes part in the compare only when it lies above the window size
    for (genvar j = CODE_MIN; j < AW; j++) begin : g_keep
        assign keep[j] = (32'(j) >= 32'(code));
    end

    assign diff    = (addr_hi ^ base) & keep;
    assign code_ok = (code >= CODE_W'(CODE_MIN)) && (code <= CODE_W'(CODE_MAX));
    assign hit     = code_ok && (diff == '0);
endmodule

// File: rtl/apu_perm_eval.sv
module apu_perm_eval #(
    parameter int unsigned NRANGE = 6
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [NRANGE-1:0] hits,
    input  logic [NRANGE-1:0] wr_en,
    input  logic [NRANGE-1:0] rd_en,
    input  logic              glob_wr,
    input  logic              glob_rd,
    input  logic              on,
    input  logic              test,
    output logic              viol_rd,
    output logic              viol_wr
);
    logic any_hit;
    logic wr_ok;
    logic rd_ok;
    logic flag;

    always_comb begin
        any_hit = |hits;
        wr_ok   = any_hit ? |(hits & wr_en) : glob_wr;
        rd_ok   = any_hit ? |(hits & rd_en) : glob_rd;
        flag    = acc_valid && on && (test || !(acc_write ? wr_ok : rd_ok));
        viol_wr = flag && acc_write;
        viol_rd = flag && !acc_write;
    end
endmodule

// File: rtl/apu_top.sv
module apu_top
    import apu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic                 cfg_rd,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    input  logic                 acc_valid,
    input  logic                 acc_write,
    input  logic [REG_W-1:0]     acc_addr,
    output logic [REG_W-1:0]     irq_vec
);
    localparam int unsigned PAD_W = CODE_MIN - CODE_W;

    typedef struct packed {
        range_cfg_t [NRANGE-1:0] rng;
        priv_t                   priv;
        logic [REG_W-1:0]        vaddr;
        logic                    lock;
        logic                    irq_rd;
        logic                    irq_wr;
    } state_t;

    state_t st_d, st_q;

    logic [NRANGE-1:0] hits;
    logic              viol_rd;
    logic              viol_wr;
    logic              touch_vaddr;

    for (genvar i = 0; i < NRANGE; i++) begin : g_rng
        apu_range_match #(
            .AW       (REG_W),
            .CODE_W   (CODE_W),
            .CODE_MIN (CODE_MIN),
            .CODE_MAX (CODE_MAX)
        ) u_match (
            .addr_hi (acc_addr[REG_W-1:CODE_MIN]),
            .base    (st_q.rng[i].base),
            .code    (st_q.rng[i].code),
            .hit     (hits[i])
        );
    end

    apu_perm_eval #(.NRANGE(NRANGE)) u_perm (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .hits      (hits),
        .wr_en     (st_q.priv.wr_en),
        .rd_en     (st_q.priv.rd_en),
        .glob_wr   (st_q.priv.glob_wr),
        .glob_rd   (st_q.priv.glob_rd),
        .on        (st_q.priv.on),
        .test      (st_q.priv.test),
        .viol_rd   (viol_rd),
        .viol_wr   (viol_wr)
    );

    assign touch_vaddr = (cfg_wr || cfg_rd) && (cfg_sel == SEL_VADDR);

    always_comb begin
        st_d        = st_q;
        st_d.irq_rd = viol_rd;
        st_d.irq_wr = viol_wr;
        if (cfg_wr) begin
            for (int i = 0; i < NRANGE; i++) begin
                if (cfg_sel == SEL_W'(i)) begin
                    st_d.rng[i].base = cfg_wdata[REG_W-1:CODE_MIN];
                    st_d.rng[i].code = cfg_wdata[CODE_W-1:0];
                end
            end
            if (cfg_sel == SEL_PRIV) begin
                st_d.priv = priv_unpack(cfg_wdata);
            end
            if (cfg_sel == SEL_VADDR) begin
                st_d.vaddr = cfg_wdata;
            end
        end
        if (touch_vaddr) begin
            st_d.lock = 1'b0;
        end
        if ((viol_rd || viol_wr) && !st_d.lock) begin
            st_d.vaddr = acc_addr;
            st_d.lock  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NRANGE; i++) begin
            if (cfg_sel == SEL_W'(i)) begin
                cfg_rdata = {st_q.rng[i].base, {PAD_W{1'b0}}, st_q.rng[i].code};
            end
        end
        if (cfg_sel == SEL_PRIV) begin
            cfg_rdata = priv_pack(st_q.priv);
        end
        if (cfg_sel == SEL_VADDR) begin
            cfg_rdata = st_q.vaddr;
        end
    end

    always_comb begin
        irq_vec         = '0;
        irq_vec[IRQ_RD] = st_q.irq_rd;
        irq_vec[IRQ_WR] = st_q.irq_wr;
    end

    // R9: a single access never raises both directions
    p_irq_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_vec[IRQ_RD] && irq_vec[IRQ_WR]));

    // R9: a write access never shows up as a read violation
    p_write_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> !irq_vec[IRQ_RD]);

    // R7: unit switched off stays quiet
    p_quiet_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.priv.on |=> (irq_vec == '0));

    // R11: no access, no interrupt
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (irq_vec == '0));

    // R8: test mode flags every access
    p_test_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && st_q.priv.on && st_q.priv.test) |=> (irq_vec != '0));

    // R10: a locked capture holds until software touches it
    p_hold_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lock && !touch_vaddr) |=> $stable(st_q.vaddr));
endmodule

// File: tb/tb_apu_top.sv
module tb_apu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_rd = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [31:0] irq_vec;

    int unsigned n_chk  = 0;
    int unsigned n_fail = 0;
    int unsigned cyc    = 0;
    bit          done   = 1'b0;

    // bench model of software-visible state
    logic [31:0] m_base [6];
    logic [4:0]  m_code [6];
    logic [31:0] m_priv;
    logic [31:0] m_vaddr;
    bit          m_lock;

    always #2 clk = ~clk;   // 250 MHz

    apu_top dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .irq_vec(irq_vec)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    function automatic bit exp_hit(int i, logic [31:0] a);
        int c = int'(m_code[i]);
        if (c < 9 || c > 21) return 1'b0;
        return (a >> c) == (m_base[i] >> c);
    endfunction

    function automatic logic [31:0] exp_irq(bit w, logic [31:0] a);
        logic [5:0] h;
        bit ok;
        bit viol;
        for (int i = 0; i < 6; i++) h[i] = exp_hit(i, a);
        if (h != 0) ok = w ? |(h & m_priv[5:0]) : |(h & m_priv[15:10]);
        else        ok = w ? m_priv[9] : m_priv[19];
        viol = m_priv[31] && (m_priv[30] || !ok);
        if (!viol) return 32'h0;
        return w ? 32'h0040_0000 : 32'h0080_0000;
    endfunction

    function automatic logic [31:0] exp_read(int sel);
        if (sel < 6) return m_base[sel] | {27'd0, m_code[sel]};
        if (sel == 6) return m_priv;
        return m_vaddr;
    endfunction

    task automatic cfg_write(int sel, logic [31:0] d);
        cfg_wr = 1'b1; cfg_sel = 3'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (sel < 6) begin
            m_base[sel] = d & 32'hFFFF_FE00;
            m_code[sel] = d[4:0];
        end else if (sel == 6) begin
            m_priv = d & 32'hC008_FE3F;
        end else begin
            m_vaddr = d; m_lock = 1'b0;
        end
    endtask

    task automatic cfg_read(int sel, string tag);
        cfg_sel = 3'(sel); cfg_rd = 1'b1;
        #1;
        chk(tag, cfg_rdata, exp_read(sel));
        @(negedge clk);
        cfg_rd = 1'b0;
        if (sel == 7) m_lock = 1'b0;
    endtask

    task automatic access(bit w, logic [31:0] a, string tag);
        logic [31:0] e;
        e = exp_irq(w, a);
        acc_valid = 1'b1; acc_write = w; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(tag, irq_vec, e);
        if (e != 0 && !m_lock) begin
            m_vaddr = a; m_lock = 1'b1;
        end
        @(negedge clk);
        chk({tag, " pulse end R9"}, irq_vec, 32'h0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 6; i++) begin m_base[i] = 0; m_code[i] = 0; end
        m_priv = 0; m_vaddr = 0; m_lock = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq after reset", irq_vec, 32'h0);
        for (int s = 0; s < 8; s++) cfg_read(s, "R1 reset readback");

        // R2 / R3 field masks
        cfg_write(2, 32'hFFFF_FFFF);
        cfg_read(2, "R2 window readback");
        chk("R2 all-ones window", exp_read(2), 32'hFFFF_FE1F);
        cfg_write(6, 32'hFFFF_FFFF);
        cfg_read(6, "R3 rights readback");
        chk("R3 all-ones rights", exp_read(6), 32'hC008_FE3F);

        // R7 unit off: no interrupt even with no grants
        cfg_write(6, 32'h0);
        access(1'b1, 32'h1234_5678, "R7 off write");
        access(1'b0, 32'h0000_0000, "R7 off read");

        // R4 window boundaries: code 9 at 0x1000, only window 0 valid
        for (int i = 0; i < 6; i++) cfg_write(i, 32'h0);
        cfg_write(0, 32'h0000_1000 | 32'd9);
        cfg_write(6, 32'h8000_0001);   // on, window 0 write grant only
        access(1'b1, 32'h0000_1000, "R4 low edge hit");
        access(1'b1, 32'h0000_11FF, "R4 last byte hit");
        access(1'b1, 32'h0000_1200, "R4 one past miss");
        cfg_read(7, "R10 first capture");
        access(1'b1, 32'h0000_0FFF, "R4 one below miss");
        cfg_read(7, "R10 capture after unlock");

        // R4 invalid codes never hit
        cfg_write(0, 32'h0000_0000 | 32'd8);
        access(1'b1, 32'h0000_0010, "R4 code 8 disabled");
        cfg_read(7, "R4 capture code 8");
        cfg_write(0, 32'h0000_0000 | 32'd22);
        access(1'b1, 32'h0000_0010, "R4 code 22 disabled");
        // R4 largest window 2 MB
        cfg_write(0, 32'h0060_0000 | 32'd21);
        access(1'b1, 32'h007F_FFFF, "R4 2MB top hit");
        access(1'b1, 32'h0080_0000, "R4 2MB past miss");

        // R5 overlap: window 1 grants read, window 0 does not
        cfg_write(1, 32'h0060_0000 | 32'd12);
        cfg_write(6, 32'h8000_0800);   // read grant window 1 only
        access(1'b0, 32'h0060_0010, "R5 overlap granted read");
        access(1'b0, 32'h0061_0010, "R5 only window 0 read");

        // R6 fallback grants
        cfg_write(6, 32'h8008_0000);   // fallback read only
        access(1'b0, 32'h4000_0000, "R6 fallback read ok");
        access(1'b1, 32'h4000_0000, "R6 fallback write denied");
        cfg_write(6, 32'h8000_0200);   // fallback write only
        access(1'b1, 32'h4000_0000, "R6 fallback write ok");

        // R8 test bit overrides grants
        cfg_write(6, 32'hC008_FE3F);
        access(1'b0, 32'h0060_0000, "R8 test read");
        access(1'b1, 32'h4000_0000, "R8 test write");

        // R10 hold first, write loads and unlocks
        cfg_read(7, "R10 unlock");
        access(1'b1, 32'hAAAA_0000, "R10 first fault");
        access(1'b0, 32'hBBBB_0000, "R10 second fault");
        cfg_read(7, "R10 holds first");
        access(1'b0, 32'hCCCC_0000, "R10 locked fault");
        cfg_write(7, 32'h1357_9BDF);
        cfg_read(7, "R10 write loads");
        access(1'b0, 32'hDDDD_0000, "R10 capture after write");
        cfg_read(7, "R10 capture after write rd");

        // R11 idle cycle with a faulting address on the bus
        acc_valid = 1'b0; acc_write = 1'b1; acc_addr = 32'hEEEE_0000;
        @(negedge clk);
        chk("R11 idle no irq", irq_vec, 32'h0);
        cfg_read(7, "R11 idle no capture");

        // constrained random
        for (int k = 0; k < 60; k++) begin
            for (int i = 0; i < 6; i++)
                cfg_write(i, ($urandom() & 32'hFFFF_FE00) | 32'($urandom_range(7, 23)));
            cfg_write(6, $urandom() | (($urandom_range(0, 7) != 0) ? 32'h8000_0000 : 32'h0)
                         & (($urandom_range(0, 7) != 0) ? 32'hBFFF_FFFF : 32'hFFFF_FFFF));
            for (int t = 0; t < 30; t++) begin
                int r = int'($urandom_range(0, 5));
                logic [31:0] a;
                if ($urandom_range(0, 3) == 0) a = $urandom();
                else if (m_code[r] <= 5'd21)
                    a = m_base[r] | ($urandom() & ((32'd1 << m_code[r]) - 1));
                else a = m_base[r] | ($urandom() & 32'h1FF);
                access(1'($urandom_range(0, 1)), a, "R5 R6 R9 random access");
                if ($urandom_range(0, 4) == 0) cfg_read(7, "R10 random capture");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule